// File: doc/BRIEF.md
# Master-clocked serial result port for a sampling converter

This block sends each 16-bit conversion result out over a three-wire serial link whose bit clock it makes itself by dividing the system clock. A conversion controller feeds it the result word, a one-cycle conversion-done pulse and its busy level. The block drives a data line, a bit clock and a frame marker. It also drives a busy output that the host watches in place of the controller's own busy signal.

Two read timings are available. In read-after mode a frame starts as soon as a conversion finishes, and the busy output stays high until the frame is complete. In read-during mode the finished result is held back and sent while the next conversion runs, so busy is not extended. Static configuration inputs set the frame marker's active level, invert the bit clock, and choose straight binary or two's complement (the MSB inverted). A chip-select input controls the output-enable signal for the three serial pads.

Top module: `adc_mserial_port`

## Requirements
- R1: After reset, busy_out is 0, sdout is 0, sclk sits at its idle level (equal to cfg_inv_sclk) and sync sits at its inactive level (equal to cfg_inv_sync).
- R2: A frame carries exactly 16 bits, MSB first. The internal bit clock is low for SCLK_HALF system cycles and then high for SCLK_HALF cycles. sdout changes only at the start of a bit, when the internal clock falls, and is stable while the internal clock is high.
- R3: With cfg_twos_comp = 0 the sent word equals the result. With cfg_twos_comp = 1 bit 15 is inverted and bits 14..0 are unchanged.
- R4: sync is active for exactly 32*SCLK_HALF system cycles per frame. Its active level is 1 when cfg_inv_sync = 0 and 0 when cfg_inv_sync = 1.
- R5: sclk equals the internal bit clock XOR cfg_inv_sclk, and the internal clock is 0 outside a frame.
- R6: With cfg_read_during = 0, sync becomes active one cycle after conv_done is sampled. busy_out stays high, with no gap, from the conv_done cycle through the end of the frame plus one cycle: 32*SCLK_HALF+2 cycles after conv_busy falls.
- R7: In read-after mode, sync returns to its inactive level one cycle before busy_out falls.
- R8: With cfg_read_during = 1, conv_done only stores the result. A frame with the stored word starts on the next rising edge of conv_busy. Without a stored word, no frame starts. busy_out equals conv_busy in this mode.
- R9: A conv_done pulse, or a rise of conv_busy, that arrives while a frame is in progress does not start a second frame. A read-after conv_done in that window is discarded.
- R10: port_oe is 1 exactly when cs_n is 0, independent of frame activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_read_during | input | 1 | 1: send during next conversion; 0: send after conversion |
| cfg_inv_sync | input | 1 | 1: sync active low |
| cfg_inv_sclk | input | 1 | 1: invert sclk |
| cfg_twos_comp | input | 1 | 1: invert MSB of the result |
| cs_n | input | 1 | Chip select, active low |
| conv_busy | input | 1 | Busy level from the conversion controller |
| conv_done | input | 1 | One-cycle pulse, result valid |
| conv_result | input | 16 | Conversion result |
| busy_out | output | 1 | Busy seen by the host |
| sclk | output | 1 | Serial bit clock |
| sdout | output | 1 | Serial data |
| sync | output | 1 | Frame marker |
| port_oe | output | 1 | Pad enable for sclk, sdout, sync |

## Verification
The bench decodes each frame from the pins and checks its bit count, its sync length and the word it carries, over random results, polarities and formats. A design that shifted on the wrong clock edge would show a shifted or duplicated bit. Directed cases check that busy_out has no gap when conversion ends, and that it falls exactly one cycle after sync. A late or early tail would change that count. In read-during mode the bench checks that no frame starts at conv_done and that nothing is sent on the first conversion after reset. It also checks that a second done pulse in the middle of a frame neither restarts the frame nor replaces the word being sent.

// File: rtl/adc_ms_pkg.sv
package adc_ms_pkg;
  localparam int unsigned WORD_W = 16;
  typedef logic [WORD_W-1:0] word_t;

  // apply output coding: two's complement inverts the sign position
  function automatic word_t code_word(input word_t raw, input logic twos);
    word_t r;
    r = raw;
    r[WORD_W-1] = raw[WORD_W-1] ^ twos;
    return r;
  endfunction
endpackage

// File: rtl/ms_clkdiv.sv
module ms_clkdiv #(
  parameter int unsigned SCLK_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sck,
  output logic bit_end
);
  localparam int unsigned PERIOD = 2 * SCLK_HALF;
  localparam int unsigned CW     = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
  localparam logic [CW-1:0] HI   = CW'(SCLK_HALF);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)              cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign sck     = run && (cnt_q >= HI);
  assign bit_end = run && (cnt_q == LAST);
endmodule

// File: rtl/ms_shifter.sv
module ms_shifter
  import adc_ms_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  word_t load_word,
  input  logic  shift,
  output logic  msb,
  output logic  last_bit
);
  localparam int unsigned BW = $clog2(WORD_W);
  localparam logic [BW-1:0] LASTIDX = BW'(WORD_W - 1);

  word_t         sh_q, sh_d;
  logic [BW-1:0] idx_q, idx_d;

  always_comb begin
    sh_d  = sh_q;
    idx_d = idx_q;
    if (load) begin
      sh_d  = load_word;
      idx_d = '0;
    end else if (shift) begin
      sh_d  = {sh_q[WORD_W-2:0], 1'b0};
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else begin
      sh_q  <= sh_d;
      idx_q <= idx_d;
    end
  end

  assign msb      = sh_q[WORD_W-1];
  assign last_bit = (idx_q == LASTIDX);
endmodule

// File: rtl/adc_mserial_port.sv
module adc_mserial_port
  import adc_ms_pkg::*;
#(
  parameter int unsigned SCLK_HALF = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_read_during,
  input  logic        cfg_inv_sync,
  input  logic        cfg_inv_sclk,
  input  logic        cfg_twos_comp,
  input  logic        cs_n,
  input  logic        conv_busy,
  input  logic        conv_done,
  input  logic [15:0] conv_result,
  output logic        busy_out,
  output logic        sclk,
  output logic        sdout,
  output logic        sync,
  output logic        port_oe
);
  logic  active_q, active_d;
  logic  tail_q, tail_d;
  logic  pend_v_q, pend_v_d;
  word_t pend_w_q, pend_w_d;
  logic  cbusy_q;

  logic  sck, bit_end, msb, last_bit;
  logic  busy_rise, start_after, start_during, start;
  logic  frame_end;
  word_t load_word;

  assign busy_rise    = conv_busy && !cbusy_q;
  assign start_after  = !cfg_read_during && conv_done && !active_q;
  assign start_during = cfg_read_during && busy_rise && pend_v_q && !active_q;
  assign start        = start_after || start_during;
  assign frame_end    = active_q && bit_end && last_bit;
  assign load_word    = start_during ? code_word(pend_w_q, cfg_twos_comp)
                                     : code_word(conv_result, cfg_twos_comp);

  always_comb begin
    active_d = active_q;
    if (start)          active_d = 1'b1;
    else if (frame_end) active_d = 1'b0;
    tail_d = frame_end;
    pend_v_d = pend_v_q;
    pend_w_d = pend_w_q;
    if (start_during) pend_v_d = 1'b0;
    if (cfg_read_during && conv_done) begin
      pend_v_d = 1'b1;
      pend_w_d = conv_result;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      tail_q   <= 1'b0;
      pend_v_q <= 1'b0;
      pend_w_q <= '0;
      cbusy_q  <= 1'b0;
    end else begin
      active_q <= active_d;
      tail_q   <= tail_d;
      pend_v_q <= pend_v_d;
      pend_w_q <= pend_w_d;
      cbusy_q  <= conv_busy;
    end
  end

  ms_clkdiv #(.SCLK_HALF(SCLK_HALF)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (active_q),
    .sck     (sck),
    .bit_end (bit_end)
  );

  ms_shifter u_sh (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start),
    .load_word (load_word),
    .shift     (bit_end && active_q),
    .msb       (msb),
    .last_bit  (last_bit)
  );

  assign sdout    = active_q && msb;
  assign sclk     = sck ^ cfg_inv_sclk;
  assign sync     = active_q ^ cfg_inv_sync;
  assign port_oe  = !cs_n;
  assign busy_out = conv_busy ||
                    (!cfg_read_during && (start_after || active_q || tail_q));
endmodule

// File: rtl/adc_mserial_chk.sv
module adc_mserial_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_read_during,
  input logic cfg_inv_sync,
  input logic cfg_inv_sclk,
  input logic conv_busy,
  input logic conv_done,
  input logic busy_out,
  input logic sclk,
  input logic sdout,
  input logic sync
);
  logic fr, ck;
  assign fr = sync ^ cfg_inv_sync;
  assign ck = sclk ^ cfg_inv_sclk;

  // R2
  sdout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fr && ck && $past(ck)) |-> $stable(sdout));

  // R5
  idle_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fr |-> !ck);

  // R6
  busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_read_during && fr) |-> busy_out);

  // R7
  sync_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_read_during && $fell(fr)) |-> busy_out);

  // R8
  during_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_read_during && !conv_busy) |-> !busy_out);

  // R8
  during_nostart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_read_during && conv_done && !conv_busy && !fr) |=> !fr);
endmodule

bind adc_mserial_port adc_mserial_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cfg_read_during (cfg_read_during),
  .cfg_inv_sync    (cfg_inv_sync),
  .cfg_inv_sclk    (cfg_inv_sclk),
  .conv_busy       (conv_busy),
  .conv_done       (conv_done),
  .busy_out        (busy_out),
  .sclk            (sclk),
  .sdout           (sdout),
  .sync            (sync)
);

// File: tb/tb_adc_mserial_port.sv
module tb_adc_mserial_port;
  localparam int HALF = 2;
  localparam int FLEN = 32 * HALF;

  logic clk = 0, rst_n = 0;
  logic cfg_read_during = 0, cfg_inv_sync = 0, cfg_inv_sclk = 0, cfg_twos_comp = 0;
  logic cs_n = 1, conv_busy = 0, conv_done = 0;
  logic [15:0] conv_result = 0;
  logic busy_out, sclk, sdout, sync, port_oe;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  adc_mserial_port #(.SCLK_HALF(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_read_during(cfg_read_during),
    .cfg_inv_sync(cfg_inv_sync), .cfg_inv_sclk(cfg_inv_sclk),
    .cfg_twos_comp(cfg_twos_comp), .cs_n(cs_n), .conv_busy(conv_busy),
    .conv_done(conv_done), .conv_result(conv_result), .busy_out(busy_out),
    .sclk(sclk), .sdout(sdout), .sync(sync), .port_oe(port_oe));

  // frame monitor, sampled at the falling system edge
  int frames = 0, nb = 0, len = 0, last_nb = 0, last_len = 0;
  logic [15:0] word = 0, last_word = 0;
  logic prev_ck = 0, prev_fr = 0;
  always @(negedge clk) begin
    logic fr, ck;
    fr = sync ^ cfg_inv_sync;
    ck = sclk ^ cfg_inv_sclk;
    if (fr) begin
      len = len + 1;
      if (ck && !prev_ck) begin word = {word[14:0], sdout}; nb = nb + 1; end
    end else if (prev_fr) begin
      frames = frames + 1; last_word = word; last_nb = nb; last_len = len;
      nb = 0; len = 0; word = 0;
    end
    prev_ck = ck; prev_fr = fr;
  end

  function automatic logic [15:0] expw(input logic [15:0] r, input logic t);
    return {r[15] ^ t, r[14:0]};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // finish a conversion: drop busy, pulse done; returns busy_out high count
  task automatic finish_conv(input logic [15:0] w, output int bcnt);
    tick(1);
    conv_busy = 0; conv_done = 1; conv_result = w;
    bcnt = 0;
    @(negedge clk); if (busy_out) bcnt++;
    tick(1); conv_done = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (busy_out) bcnt++; else break;
    end
  endtask

  task automatic after_frame(input logic [15:0] w, input string tag);
    int f0, bc;
    f0 = frames;
    conv_busy = 1; tick(8);
    finish_conv(w, bc);
    tick(4);
    check(frames == f0 + 1, tag, frames - f0, 1);
    check(last_word == expw(w, cfg_twos_comp), tag, last_word, expw(w, cfg_twos_comp));
    check(last_nb == 16 && last_len == FLEN, tag, last_len, FLEN);
    check(bc == FLEN + 2, "R6 busy extension", bc, FLEN + 2);
  endtask

  bit done_flag = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int f0, bc;
    void'($urandom(1234));
    tick(3);
    // R1 reset state
    check(!busy_out && !sdout && !sclk && !sync, "R1 reset", {busy_out, sdout, sclk, sync}, 0);
    check(!port_oe, "R10 oe off", port_oe, 0);
    rst_n = 1; tick(2);
    cs_n = 0; tick(1);
    check(port_oe, "R10 oe on", port_oe, 1);

    // R2 R3 R4 R6 directed
    after_frame(16'h8001, "R2 msb-first");
    cfg_twos_comp = 1;
    after_frame(16'h8001, "R3 twos");
    cfg_inv_sync = 1; cfg_inv_sclk = 1; cfg_twos_comp = 0; tick(1);
    check(sync == 1 && sclk == 1, "R5 R4 idle inverted", {sync, sclk}, 3);
    after_frame(16'h5A3C, "R4 R5 inverted");

    // R7 sync falls one cycle before busy_out
    cfg_inv_sync = 0; cfg_inv_sclk = 0;
    conv_busy = 1; tick(5);
    tick(1); conv_busy = 0; conv_done = 1; conv_result = 16'h1234;
    tick(1); conv_done = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (sync) break; end
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (!sync) break; end
    check(busy_out, "R7 busy after sync", busy_out, 1);
    @(negedge clk);
    check(!busy_out, "R7 busy falls", busy_out, 0);
    tick(4);

    // R9 second done mid-frame is discarded
    f0 = frames;
    tick(1); conv_done = 1; conv_result = 16'hA5A5;
    tick(1); conv_done = 0;
    tick(10); conv_done = 1; conv_result = 16'h0F0F;
    tick(1); conv_done = 0;
    tick(300);
    check(frames == f0 + 1, "R9 one frame", frames - f0, 1);
    check(last_word == 16'hA5A5, "R9 word kept", last_word, 16'hA5A5);

    // R10 cs has no effect on frame, only oe
    cs_n = 1; tick(1);
    check(!port_oe, "R10 cs high", port_oe, 0);
    after_frame(16'h7FFF, "R10 frame with cs high");
    cs_n = 0;

    // R8 read-during
    cfg_read_during = 1; tick(2);
    rst_n = 0; tick(2); rst_n = 1; tick(2);
    f0 = frames;
    conv_busy = 1; tick(100);   // no stored word: nothing sent
    check(frames == f0 && !sync, "R8 no stored word", frames - f0, 0);
    finish_conv(16'hBEEF, bc);
    check(bc == 0, "R8 busy not extended", bc, 0);
    tick(20);
    check(frames == f0 && !sync, "R8 no frame at done", frames - f0, 0);
    conv_busy = 1; tick(100);
    check(frames == f0 + 1 && last_word == 16'hBEEF, "R8 previous word", last_word, 16'hBEEF);
    finish_conv(16'h0042, bc);
    conv_busy = 1; tick(100);
    check(last_word == 16'h0042, "R8 next word", last_word, 16'h0042);
    // R9 busy rise during an active frame does not restart
    finish_conv(16'h1111, bc);
    conv_busy = 1; tick(10);
    conv_busy = 0; conv_done = 1; conv_result = 16'h2222; tick(1); conv_done = 0;
    tick(3); conv_busy = 1; tick(100);
    check(last_word == 16'h1111 && last_nb == 16, "R9 during no restart", last_word, 16'h1111);
    conv_busy = 1; tick(2); conv_busy = 0; tick(4); conv_busy = 1; tick(100);
    check(last_word == 16'h2222, "R9 during held word", last_word, 16'h2222);
    conv_busy = 0;
    cfg_read_during = 0; tick(4);

    // random read-after frames
    for (int k = 0; k < 20; k++) begin
      cfg_inv_sync = $urandom % 2; cfg_inv_sclk = $urandom % 2;
      cfg_twos_comp = $urandom % 2; tick(2);
      after_frame(16'($urandom), "R2 R3 R4 random");
    end

    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule